// File: doc/BRIEF.md
# Programmable CPU Clock Divider

This block turns a clock source into a processor clock enable. The enable pulses once per divided period. Two sources are available: the fast internal oscillator, which is the block's own clock, and an external clock pin. The external pin is sampled through a synchronizer, and each detected edge counts as one source tick. A one-bit source select and a three-bit speed code set the divisor. The same code table applies to both sources.

Software-style writes land in a small configuration register. A new divisor and a new source are taken up by the divider only at the end of the output period in progress, so no period is ever cut short. Before it reaches the divider, a source change passes through a two-flop synchronizer.

Top module: `cpuclk_div`

## Requirements
- R1: While reset is asserted `cpu_en_o` is low. After reset the block runs on the internal source with speed code 000 (divide by 8), so the first enable pulse is seen on the 7th clock cycle after reset release, and pulses then repeat every 8 cycles.
- R2: On the internal source, `cpu_en_o` pulses once in every N clock cycles, where N is the active divisor.
- R3: Speed codes map to divisors as follows: 000 gives 8, 001 gives 4, 010 gives 2, 100 gives 16, 101 gives 32 and 110 gives 128.
- R4: Writing code 011 or 111 leaves the active divisor unchanged. The select bit in that same write is still applied.
- R5: A divisor change takes effect only at an enable pulse. The period in progress when the write occurs completes at the old length.
- R6: With `wr_src_sel_i`=1 stored (external source), the block counts rising edges of `ext_clk_i`, taken after a synchronizer of `SYNC_STAGES` flops. It pulses once per N such edges, and only in a cycle where an edge was detected.
- R7: A source change passes through two synchronizer flops and then switches at an enable pulse. The period in progress completes on the old source.
- R8: `cpu_en_o` is never high in two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock; all flops run on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration register |
| wr_src_sel_i | input | 1 | Source select to store: 0 internal, 1 external |
| wr_speed_i | input | 3 | Speed code to store |
| ext_clk_i | input | 1 | External clock input, asynchronous to clk_i |
| cpu_en_o | output | 1 | One-cycle processor clock enable |

## Verification
Every interval between enable pulses is measured and compared against the divisor expected from the most recent write. All six legal codes are applied on the internal source. Writes are placed both on a pulse and several cycles into a period, which separates a divider that reloads at the boundary from one that reloads at once. The reserved codes are written on both sources, which shows whether the old divisor is kept while the select bit still changes. Source switches in each direction check that the period in progress ends on the old source and that the next periods follow the external edge rate multiplied by the divisor.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

   localparam int unsigned SPEED_W = 3;

   typedef logic [SPEED_W-1:0] speed_code_t;

   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   // Codes with no divisor assigned.
   function automatic logic code_reserved(input speed_code_t code);
      return (code == 3'b011) || (code == 3'b111);
   endfunction

   // log2 of the divisor for a speed code; reserved codes fall back to /8.
   function automatic logic [2:0] code_log2(input speed_code_t code);
      logic [2:0] lg;
      case (code)
         3'b000:  lg = 3'd3;
         3'b001:  lg = 3'd2;
         3'b010:  lg = 3'd1;
         3'b100:  lg = 3'd4;
         3'b101:  lg = 3'd5;
         3'b110:  lg = 3'd7;
         default: lg = 3'd3;
      endcase
      return lg;
   endfunction

endpackage

// File: rtl/cpuclk_cfg_reg.sv
module cpuclk_cfg_reg
   import cpuclk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  speed_code_t wr_speed,
   output clk_src_e    sel_q,
   output speed_code_t speed_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= SRC_INT;
         speed_q <= 3'b000;
      end else if (wr_en) begin
         sel_q <= clk_src_e'(wr_sel);
         if (!code_reserved(wr_speed)) begin
            speed_q <= wr_speed;
         end
      end
   end

endmodule

// File: rtl/cpuclk_src_sync.sv
module cpuclk_src_sync
   import cpuclk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_RISING  = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ext_clk,
   input  clk_src_e sel_req,
   output logic     ext_tick,
   output clk_src_e sel_sync
);

   // Synchronizer chain plus one extra flop for edge detection.
   logic [SYNC_STAGES:0] ext_sh;
   logic [1:0]           sel_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sh <= '0;
      end else begin
         ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
      end
   end

   generate
      if (EXT_RISING) begin : g_rise
         assign ext_tick = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
      end else begin : g_fall
         assign ext_tick = ~ext_sh[SYNC_STAGES-1] & ext_sh[SYNC_STAGES];
      end
   endgenerate

   // Two-flop handshake for the source select.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_sh <= '0;
      end else begin
         sel_sh <= {sel_sh[0], logic'(sel_req)};
      end
   end

   assign sel_sync = clk_src_e'(sel_sh[1]);

endmodule

// File: rtl/cpuclk_div_core.sv
module cpuclk_div_core
   import cpuclk_pkg::*;
#(
   parameter int unsigned CNT_W = 7,
   localparam int unsigned LG_W = $clog2(CNT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_tick,
   input  clk_src_e         sel_sync,
   input  speed_code_t      speed_cfg,
   output logic             en,
   output clk_src_e         sel_act,
   output logic [LG_W-1:0]  lg_act,
   output logic [CNT_W-1:0] cnt
);

   logic             tick;
   logic             term;
   logic [CNT_W-1:0] mask;

   assign tick = (sel_act == SRC_EXT) ? ext_tick : 1'b1;
   assign mask = ~({CNT_W{1'b1}} << lg_act);
   assign term = (cnt == mask);
   assign en   = tick & term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         lg_act  <= LG_W'(3);
         sel_act <= SRC_INT;
      end else if (tick) begin
         if (term) begin
            cnt     <= '0;
            lg_act  <= LG_W'(code_log2(speed_cfg));
            sel_act <= sel_sync;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpuclk_div.sv
module cpuclk_div
   import cpuclk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_RISING  = 1'b1,
   parameter int unsigned CNT_W       = 7
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_en_i,
   input  logic       wr_src_sel_i,
   input  logic [2:0] wr_speed_i,
   input  logic       ext_clk_i,
   output logic       cpu_en_o
);

   localparam int unsigned LG_W = $clog2(CNT_W + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 7) begin : g_bad_cnt
         $error("CNT_W must hold a count of 128");
      end
   endgenerate

   clk_src_e         sel_q_w;
   speed_code_t      speed_w;
   logic             ext_tick_w;
   clk_src_e         sel_sync_w;
   clk_src_e         sel_act_w;
   logic [LG_W-1:0]  lg_w;
   logic [CNT_W-1:0] cnt_w;

   cpuclk_cfg_reg u_cfg (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .wr_en    (wr_en_i),
      .wr_sel   (wr_src_sel_i),
      .wr_speed (wr_speed_i),
      .sel_q    (sel_q_w),
      .speed_q  (speed_w)
   );

   cpuclk_src_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .EXT_RISING  (EXT_RISING)
   ) u_sync (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .ext_clk  (ext_clk_i),
      .sel_req  (sel_q_w),
      .ext_tick (ext_tick_w),
      .sel_sync (sel_sync_w)
   );

   cpuclk_div_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .ext_tick  (ext_tick_w),
      .sel_sync  (sel_sync_w),
      .speed_cfg (speed_w),
      .en        (cpu_en_o),
      .sel_act   (sel_act_w),
      .lg_act    (lg_w),
      .cnt       (cnt_w)
   );

endmodule

// File: rtl/cpuclk_div_chk.sv
module cpuclk_div_chk
   import cpuclk_pkg::*;
#(
   parameter int unsigned CNT_W = 7,
   parameter int unsigned LG_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             ext_tick,
   input clk_src_e         sel_act,
   input speed_code_t      speed_q,
   input logic [LG_W-1:0]  lg,
   input logic [CNT_W-1:0] cnt
);

   // R8: the enable never lasts two cycles
   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> !en);

   // R4: the stored code is never a reserved one
   p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !code_reserved(speed_q));

   // R5: the divisor only moves at a pulse
   p_ratio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(lg));

   // R7: the active source only moves at a pulse
   p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(sel_act));

   // R6: on the external source a pulse needs a detected edge
   p_ext_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act == SRC_EXT && !ext_tick) |-> !en);

   // R2: the count stays below the active divisor
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >> lg) == '0);

endmodule

bind cpuclk_div cpuclk_div_chk #(
   .CNT_W (CNT_W),
   .LG_W  (LG_W)
) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .en       (cpu_en_o),
   .ext_tick (ext_tick_w),
   .sel_act  (sel_act_w),
   .speed_q  (speed_w),
   .lg       (lg_w),
   .cnt      (cnt_w)
);

// File: tb/cpuclk_div_tb.sv
module cpuclk_div_tb;

   localparam int CLK_PERIOD = 10;
   localparam int EXT_HALF   = 3;

   typedef struct {
      int    n;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [2:0] wr_speed = 3'b000;
   logic       ext_clk = 1'b0;
   logic       en;

   int   vectors = 0;
   int   fails = 0;
   exp_t q[$];
   event pulse_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpuclk_div u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .wr_en_i      (wr_en),
      .wr_src_sel_i (wr_sel),
      .wr_speed_i   (wr_speed),
      .ext_clk_i    (ext_clk),
      .cpu_en_o     (en)
   );

   // external clock: period of 2*EXT_HALF internal cycles
   initial begin
      forever begin
         repeat (EXT_HALF) @(negedge clk);
         ext_clk = ~ext_clk;
      end
   end

   // monitor: measures pulse spacing and pops expectations
   initial begin
      int  since;
      bit  have_prev;
      bit  prev_en;
      exp_t e;
      since = 0;
      have_prev = 0;
      prev_en = 0;
      wait (rst_n);
      forever begin
         @(negedge clk);
         since++;
         if (en) begin
            vectors++;
            if (prev_en) begin
               fails++;
               $display("FAIL R8: enable high two cycles, actual 1 expected 0");
            end
            if (have_prev && q.size() > 0) begin
               e = q.pop_front();
               if (e.n >= 0) begin
                  vectors++;
                  if (since != e.n) begin
                     fails++;
                     $display("FAIL %s: interval actual %0d expected %0d",
                              e.tag, since, e.n);
                  end
               end
            end
            have_prev = 1;
            since = 0;
            ->pulse_ev;
         end
         prev_en = en;
      end
   end

   // driver: write on a pulse (plus d cycles) and queue the intervals
   task automatic apply(input bit sel, input logic [2:0] code, input int d,
                        input int n_old, input int n_dc, input int n_new,
                        input int reps, input string tag);
      exp_t e;
      @(pulse_ev);
      repeat (d) @(negedge clk);
      wr_en = 1'b1;
      wr_sel = sel;
      wr_speed = code;
      e.tag = tag;
      e.n = n_old;
      q.push_back(e);
      for (int i = 0; i < n_dc; i++) begin
         e.n = -1;
         q.push_back(e);
      end
      for (int i = 0; i < reps; i++) begin
         e.n = n_new;
         q.push_back(e);
      end
      @(negedge clk);
      wr_en = 1'b0;
      wait (q.size() == 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int k;
      // R1: enable stays low in reset
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         vectors++;
         if (en !== 1'b0) begin
            fails++;
            $display("FAIL R1: enable in reset actual %0b expected 0", en);
         end
      end
      rst_n = 1'b1;
      // R1: first pulse after release on the 7th cycle (divide by 8)
      k = 0;
      while (k < 40) begin
         @(negedge clk);
         k++;
         if (en) break;
      end
      vectors++;
      if (k != 7) begin
         fails++;
         $display("FAIL R1: first pulse cycle actual %0d expected 7", k);
      end

      // R2 R3: legal codes on the internal source
      apply(1'b0, 3'b001, 0, 8,   0, 4,   3, "R3 code001");
      apply(1'b0, 3'b010, 1, 4,   0, 2,   4, "R3 code010");
      apply(1'b0, 3'b100, 0, 2,   0, 16,  2, "R3 code100");
      // R5: write mid-period, old length finishes first
      apply(1'b0, 3'b101, 5, 16,  0, 32,  2, "R5 code101");
      apply(1'b0, 3'b110, 0, 32,  0, 128, 2, "R3 code110");
      apply(1'b0, 3'b000, 10, 128, 0, 8,  3, "R2 code000");
      // R4: reserved code keeps divisor
      apply(1'b0, 3'b111, 0, 8,   0, 8,   3, "R4 code111");
      // R4 R6 R7: reserved code with source switch to external
      apply(1'b1, 3'b011, 0, 8,   1, 8*2*EXT_HALF, 2, "R7 to_ext");
      // R6: divisor changes on the external source
      apply(1'b1, 3'b001, 3, 8*2*EXT_HALF, 0, 4*2*EXT_HALF, 3, "R6 ext4");
      apply(1'b1, 3'b100, 0, 4*2*EXT_HALF, 0, 16*2*EXT_HALF, 2, "R6 ext16");
      // R7: back to internal, old external period completes
      apply(1'b0, 3'b010, 0, 16*2*EXT_HALF, 0, 2, 4, "R7 to_int");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule